// File: doc/BRIEF.md
# Multi-Width Serial Flash Burst Reader

This block is the host side of a serial NOR flash read path. A single start request carries a read mode, a 24-bit byte address and a byte count. The block then frames one flash access under chip select, and returns the bytes that come back on a valid/ready stream. It supports six read styles. Single-line reads come with or without dummy clocks. Fast reads can return data over two or four lines. The I/O variants also send the address over two or four lines.

Each access has four phases: opcode, address, dummy and data. Each phase has its own line width, and the read mode sets those widths. The opcode always goes out on one line. The block drives the shared data lines while it sends the address and dummy clocks. It releases them before the flash starts to answer. When the consumer applies back-pressure, the serial clock pauses. The flash address keeps advancing by itself, so a burst of any length needs only one opcode and one address.

The serial clock runs at half the system clock rate, idles low, and is sampled on its rising edge. Every serial clock therefore takes two system cycles unless it is paused.

Top module: `mio_flash_reader`

## Requirements
- R1: The mode input selects the opcode: 0→03h, 1→0Bh, 2→3Bh, 3→6Bh, 4→BBh, 5→EBh. The opcode goes out most significant bit first on IO0, one bit per serial clock.
- R2: The 24-bit address follows the opcode, most significant bits first. Modes 0–3 send it one bit per clock on IO0. Mode 4 sends two bits per clock as {IO1,IO0}. Mode 5 sends four bits per clock as {IO3,IO2,IO1,IO0}.
- R3: After the address come 0, 8, 8, 8, 4 and 6 dummy clocks for modes 0 to 5. In modes 4 and 5 the block drives all-zero bits during those clocks at the address width.
- R4: The block drops its enables on the data lines at the falling clock edge that ends the address or dummy phase. Its enables never overlap the flash's drive while chip select is low.
- R5: Data bytes are assembled most significant bit first. Modes 0 and 1 read IO1 once per clock. Modes 2 and 4 read {IO1,IO0}. Modes 3 and 5 read {IO3,IO2,IO1,IO0}.
- R6: Exactly the requested number of bytes is delivered, from consecutive flash addresses (modulo 2^24). The access uses exactly 8 + address clocks + dummy clocks + count × (8 / data width) rising clock edges.
- R7: No rising serial clock edge occurs in the cycle after one in which valid_o is high and ready_i is low. data_o holds steady until it is accepted.
- R8: Chip select stays low from the cycle after the start request until the last byte is accepted. It rises no more than two clock edges after that acceptance.
- R9: In modes 0, 1, 2 and 4, IO2 and IO3 are driven high whenever chip select is low.
- R10: A mode value of 6 or 7 raises err_o for exactly the one cycle after the request, and chip select stays high.
- R11: A request with a byte count of zero starts no access: chip select stays high and busy_o stays low.
- R12: While idle, and after reset, chip select is high, the serial clock is low, no data line is driven and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken while idle |
| mode_i | input | 3 | Read mode 0..5 |
| addr_i | input | 24 | Start byte address |
| len_i | input | LEN_W | Number of bytes to read |
| busy_o | output | 1 | An access is in progress |
| err_o | output | 1 | One-cycle flag for an unsupported mode |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_o | output | 4 | Values driven on IO3..IO0 |
| io_oe_o | output | 4 | Per-line output enables |
| io_i | input | 4 | Values sampled from IO3..IO0 |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | data_o holds a byte |
| ready_i | input | 1 | Consumer accepts the byte |

## Verification
A phase counter that is wrong shifts every later bit. The flash model then latches a wrong opcode or address, or the first data byte comes back rotated. The byte comparisons show this on the first delivered byte, and the final count of rising clock edges shows it when the access ends. A late release of the line enables shows up as bus contention at the first data clock. A missing clock pause shows up as a clock rise while a byte is still pending, and this is caught in the very next cycle.

// File: rtl/mio_rd_pkg.sv
package mio_rd_pkg;

  localparam int ADDR_W = 24;
  localparam int CNT_W  = $clog2(ADDR_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_DRAIN
  } phase_e;

  // widths are lines per clock: 1, 2 or 4
  typedef struct packed {
    logic [2:0]       aw;
    logic [2:0]       dw;
    logic [CNT_W-1:0] addr_clks;
    logic [CNT_W-1:0] dummy;
    logic [CNT_W-1:0] byte_clks;
  } rd_cfg_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return m <= 3'd5;
  endfunction

  function automatic logic [7:0] mode_opcode(input logic [2:0] m);
    case (m)
      3'd0:    return 8'h03;
      3'd1:    return 8'h0B;
      3'd2:    return 8'h3B;
      3'd3:    return 8'h6B;
      3'd4:    return 8'hBB;
      3'd5:    return 8'hEB;
      default: return 8'h00;
    endcase
  endfunction

  function automatic rd_cfg_t decode_mode(input logic [2:0] m);
    rd_cfg_t c;
    c.aw    = 3'd1;
    c.dw    = 3'd1;
    c.dummy = '0;
    case (m)
      3'd1: c.dummy = CNT_W'(8);
      3'd2: begin c.dw = 3'd2; c.dummy = CNT_W'(8); end
      3'd3: begin c.dw = 3'd4; c.dummy = CNT_W'(8); end
      3'd4: begin c.aw = 3'd2; c.dw = 3'd2; c.dummy = CNT_W'(4); end
      3'd5: begin c.aw = 3'd4; c.dw = 3'd4; c.dummy = CNT_W'(6); end
      default: ;
    endcase
    c.addr_clks = (c.aw == 3'd4) ? CNT_W'(ADDR_W / 4) :
                  (c.aw == 3'd2) ? CNT_W'(ADDR_W / 2) : CNT_W'(ADDR_W);
    c.byte_clks = (c.dw == 3'd4) ? CNT_W'(2) :
                  (c.dw == 3'd2) ? CNT_W'(4) : CNT_W'(8);
    return c;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] w);
    case (w)
      3'd4:    return 4'b1111;
      3'd2:    return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/mio_tx_shift.sv
module mio_tx_shift #(
  parameter int SR_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] load_val_i,
  input  logic            shift_i,
  input  logic [2:0]      width_i,
  output logic [3:0]      lines_o
);

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= sr_q << width_i;  // zeros fill the dummy/mode bits
  end

  always_comb begin
    case (width_i)
      3'd4:    lines_o = sr_q[SR_W-1 -: 4];
      3'd2:    lines_o = {2'b00, sr_q[SR_W-1 -: 2]};
      default: lines_o = {3'b000, sr_q[SR_W-1]};
    endcase
  end

  a_r1_load_shift_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));

endmodule

// File: rtl/mio_rx_pack.sv
module mio_rx_pack #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [2:0]    width_i,
  input  logic [3:0]    io_i,
  output logic [DW-1:0] next_o
);

  logic [DW-2:0] sr_q;

  // IO1 carries single-line data; IO3 is the top bit of a nibble
  always_comb begin
    case (width_i)
      3'd4:    next_o = {sr_q[DW-5:0], io_i[3:0]};
      3'd2:    next_o = {sr_q[DW-3:0], io_i[1:0]};
      default: next_o = {sr_q[DW-2:0], io_i[1]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (sample_i) sr_q <= next_o[DW-2:0];
  end

  a_r5_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (width_i == 3'd1 || width_i == 3'd2 || width_i == 3'd4));

endmodule

// File: rtl/mio_flash_reader.sv
module mio_flash_reader
  import mio_rd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  input  logic              ready_i
);

  localparam int SR_W = 8 + ADDR_W;

  phase_e           phase_q;
  rd_cfg_t          cfg_q, cfg_d;
  logic             sck_q, cs_nq, valid_q, err_q;
  logic [CNT_W-1:0] clk_left_q;
  logic [LEN_W-1:0] bytes_left_q;
  logic [7:0]       data_q, rx_byte;
  logic [2:0]       cur_w;
  logic [3:0]       tx_lines, oe_lo, hold_bits;
  logic             go, bad_start, rise, fall, tx_shift, rx_sample;

  assign cfg_d     = decode_mode(mode_i);
  assign go        = (phase_q == PH_IDLE) && start_i && mode_ok(mode_i) && (len_i != '0);
  assign bad_start = (phase_q == PH_IDLE) && start_i && !mode_ok(mode_i);
  assign rise      = !sck_q && !(valid_q && !ready_i);
  assign fall      = sck_q;
  assign tx_shift  = sck_q && (phase_q == PH_CMD || phase_q == PH_ADDR || phase_q == PH_DUMMY);
  assign rx_sample = rise && (phase_q == PH_DATA);

  always_comb begin
    case (phase_q)
      PH_CMD:            cur_w = 3'd1;
      PH_ADDR, PH_DUMMY: cur_w = cfg_q.aw;
      default:           cur_w = cfg_q.dw;
    endcase
  end

  mio_tx_shift #(.SR_W(SR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (go),
    .load_val_i ({mode_opcode(mode_i), addr_i}),
    .shift_i    (tx_shift),
    .width_i    (cur_w),
    .lines_o    (tx_lines)
  );

  mio_rx_pack #(.DW(8)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rx_sample),
    .width_i  (cfg_q.dw),
    .io_i     (io_i),
    .next_o   (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_IDLE;
      cfg_q        <= '0;
      sck_q        <= 1'b0;
      cs_nq        <= 1'b1;
      clk_left_q   <= '0;
      bytes_left_q <= '0;
      valid_q      <= 1'b0;
      data_q       <= '0;
      err_q        <= 1'b0;
    end else begin
      err_q <= bad_start;
      if (valid_q && ready_i) valid_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (go) begin
          cfg_q        <= cfg_d;
          cs_nq        <= 1'b0;
          phase_q      <= PH_CMD;
          clk_left_q   <= CNT_W'(8);
          bytes_left_q <= len_i;
        end
        PH_DRAIN: if (!valid_q || ready_i) begin
          cs_nq   <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: begin
          if (rise) begin
            sck_q <= 1'b1;
            if (phase_q == PH_DATA && clk_left_q == CNT_W'(1)) begin
              valid_q      <= 1'b1;
              data_q       <= rx_byte;
              bytes_left_q <= bytes_left_q - 1'b1;
            end
          end else if (fall) begin
            sck_q <= 1'b0;
            if (clk_left_q == CNT_W'(1)) begin
              case (phase_q)
                PH_CMD: begin
                  phase_q    <= PH_ADDR;
                  clk_left_q <= cfg_q.addr_clks;
                end
                PH_ADDR: begin
                  if (cfg_q.dummy != '0) begin
                    phase_q    <= PH_DUMMY;
                    clk_left_q <= cfg_q.dummy;
                  end else begin
                    phase_q    <= PH_DATA;
                    clk_left_q <= cfg_q.byte_clks;
                  end
                end
                PH_DUMMY: begin
                  phase_q    <= PH_DATA;
                  clk_left_q <= cfg_q.byte_clks;
                end
                default: begin
                  if (bytes_left_q == '0) phase_q <= PH_DRAIN;
                  else                    clk_left_q <= cfg_q.byte_clks;
                end
              endcase
            end else begin
              clk_left_q <= clk_left_q - 1'b1;
            end
          end
        end
      endcase
    end
  end

  // host drives opcode/address/dummy lanes; non-quad modes keep IO2/IO3 high
  always_comb begin
    case (phase_q)
      PH_CMD:            oe_lo = 4'b0001;
      PH_ADDR, PH_DUMMY: oe_lo = lane_mask(cfg_q.aw);
      default:           oe_lo = 4'b0000;
    endcase
    hold_bits = (!cs_nq && cfg_q.dw != 3'd4) ? 4'b1100 : 4'b0000;
  end

  assign io_oe_o = oe_lo | hold_bits;
  assign io_o    = (tx_lines & oe_lo) | hold_bits;
  assign cs_n_o  = cs_nq;
  assign sck_o   = sck_q;
  assign busy_o  = phase_q != PH_IDLE;
  assign err_o   = err_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (io_oe_o == 4'b0000 && !sck_o && !valid_o));

  a_r10_err_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cs_n_o);

  a_r7_stall_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !sck_o) |=> !sck_o);

  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  a_r8_cs_until_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> !cs_n_o);

  a_r4_released_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && sck_o && valid_o) |-> (io_oe_o[1:0] == 2'b00));

endmodule

// File: tb/mio_flash_reader_bench.sv
module mio_flash_reader_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [23:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic        busy_o, err_o, cs_n_o, sck_o, valid_o;
  logic        ready_i = 1'b1;
  logic [3:0]  io_o, io_oe_o, io_i;
  logic [7:0]  data_o;

  always #4 clk = ~clk;

  mio_flash_reader u_mio_flash_reader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .len_i(len_i), .busy_o(busy_o), .err_o(err_o),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .io_i(io_i), .data_o(data_o), .valid_o(valid_o), .ready_i(ready_i)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rdy_pat = 0;
  bit cur_nonquad = 1'b0;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], a[23:20]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model: decodes the opcode, latches address and dummy bits, streams data
  int          m_n = 0, m_aw = 1, m_dw = 1, m_dum = 0, m_ac = 24;
  logic [7:0]  m_cmd = '0, m_modeb = '0;
  logic [23:0] m_addr = '0;
  logic [3:0]  m_oe = '0, m_out = '0;
  logic        p_cs = 1'b1, p_sck = 1'b0;

  assign io_i = (m_out & m_oe) | ~m_oe;

  always @(cs_n_o, sck_o) begin
    if (cs_n_o != p_cs) begin
      if (!cs_n_o) begin
        m_n = 0; m_cmd = '0; m_addr = '0; m_modeb = '0;
        m_aw = 1; m_dw = 1; m_dum = 0; m_ac = 24;
      end else begin
        m_oe = '0;
      end
    end
    if (sck_o != p_sck && !cs_n_o) begin
      if (sck_o) begin
        if (m_n < 8) begin
          m_cmd = {m_cmd[6:0], io_o[0]};
          if (m_n == 7) begin
            case (m_cmd)
              8'h0B: begin m_dum = 8; end
              8'h3B: begin m_dw = 2; m_dum = 8; end
              8'h6B: begin m_dw = 4; m_dum = 8; end
              8'hBB: begin m_aw = 2; m_dw = 2; m_dum = 4; end
              8'hEB: begin m_aw = 4; m_dw = 4; m_dum = 6; end
              default: ;
            endcase
            m_ac = 24 / m_aw;
          end
        end else if (m_n < 8 + m_ac) begin
          if (m_aw == 4)      m_addr = {m_addr[19:0], io_o[3:0]};
          else if (m_aw == 2) m_addr = {m_addr[21:0], io_o[1:0]};
          else                m_addr = {m_addr[22:0], io_o[0]};
        end else if (m_n < 8 + m_ac + m_dum) begin
          if (m_aw == 4)      m_modeb = {m_modeb[3:0], io_o[3:0]};
          else if (m_aw == 2) m_modeb = {m_modeb[5:0], io_o[1:0]};
        end
        m_n++;
      end else if (m_n >= 8 + m_ac + m_dum) begin
        int per, k, j, p;
        logic [7:0] b;
        per = 8 / m_dw;
        k = m_n - (8 + m_ac + m_dum);
        j = k / per;
        p = k % per;
        b = mem_byte(m_addr + 24'(j));
        if (m_dw == 4) begin
          m_oe = 4'b1111; m_out = {b[7-4*p], b[6-4*p], b[5-4*p], b[4-4*p]};
        end else if (m_dw == 2) begin
          m_oe = 4'b0011; m_out = {2'b11, b[7-2*p], b[6-2*p]};
        end else begin
          m_oe = 4'b0010; m_out = {2'b11, b[7-p], 1'b1};
        end
      end
    end
    p_cs = cs_n_o;
    p_sck = sck_o;
  end

  // stream back-pressure patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (rdy_pat)
      1:       ready_i <= (cyc % 3) != 0;
      2:       ready_i <= (cyc % 16) >= 10;
      default: ready_i <= 1'b1;
    endcase
  end

  // passive monitors
  int  contention_cnt = 0, hold_bad_cnt = 0, stall_bad_cnt = 0, cs_low_cnt = 0;
  bit  prev_stall = 1'b0;
  always @(negedge clk) begin
    if (!cs_n_o && (io_oe_o & m_oe) != 4'b0000) contention_cnt++;
    if (!cs_n_o && cur_nonquad && (io_oe_o[3:2] != 2'b11 || io_o[3:2] != 2'b11)) hold_bad_cnt++;
    if (prev_stall && sck_o) stall_bad_cnt++;
    prev_stall = valid_o && !ready_i && !sck_o;
    if (!cs_n_o) cs_low_cnt++;
  end

  task automatic exp_cfg(input int mode, output logic [7:0] op, output int aw,
                         output int dw, output int dum);
    case (mode)
      0: begin op = 8'h03; aw = 1; dw = 1; dum = 0; end
      1: begin op = 8'h0B; aw = 1; dw = 1; dum = 8; end
      2: begin op = 8'h3B; aw = 1; dw = 2; dum = 8; end
      3: begin op = 8'h6B; aw = 1; dw = 4; dum = 8; end
      4: begin op = 8'hBB; aw = 2; dw = 2; dum = 4; end
      default: begin op = 8'hEB; aw = 4; dw = 4; dum = 6; end
    endcase
  endtask

  task automatic run_xfer(input int mode, input logic [23:0] a, input int len, input int rp);
    logic [7:0] op;
    int aw, dw, dum, got, waitc, c0, h0, s0, exp_rises;
    exp_cfg(mode, op, aw, dw, dum);
    rdy_pat = rp;
    cur_nonquad = !(mode == 3 || mode == 5);
    c0 = contention_cnt; h0 = hold_bad_cnt; s0 = stall_bad_cnt;
    @(negedge clk);
    mode_i = mode[2:0]; addr_i = a; len_i = len[15:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!cs_n_o && busy_o, "R8", "cs low after start", cs_n_o, 0);
    got = 0; waitc = 0;
    while (got < len && waitc < 20000) begin
      if (valid_o && ready_i) begin
        chk(data_o == mem_byte(a + 24'(got)), "R5", "data byte", data_o, mem_byte(a + 24'(got)));
        got++;
        if (got == len) chk(!cs_n_o, "R8", "cs low at last accept", cs_n_o, 0);
      end
      @(negedge clk);
      waitc++;
    end
    @(negedge clk);
    chk(cs_n_o && !busy_o, "R8", "cs high after last byte", cs_n_o, 1);
    chk(got == len, "R6", "byte count", got, len);
    chk(m_cmd == op, "R1", "opcode", m_cmd, op);
    chk(m_addr == a, "R2", "address", m_addr, a);
    if (aw > 1) chk(m_modeb == 8'h00, "R3", "mode bits", m_modeb, 0);
    exp_rises = 8 + 24 / aw + dum + len * (8 / dw);
    chk(m_n == exp_rises, "R6", "rising clock count", m_n, exp_rises);
    chk(contention_cnt == c0, "R4", "bus contention cycles", contention_cnt - c0, 0);
    chk(stall_bad_cnt == s0, "R7", "clock rise while stalled", stall_bad_cnt - s0, 0);
    if (cur_nonquad) chk(hold_bad_cnt == h0, "R9", "IO2/IO3 not high", hold_bad_cnt - h0, 0);
    chk(io_oe_o == 4'b0000 && !sck_o && !valid_o, "R12", "idle outputs", io_oe_o, 0);
  endtask

  task automatic run_reject(input int mode, input int len, input string req);
    int cs0;
    cs0 = cs_low_cnt;
    @(negedge clk);
    mode_i = mode[2:0]; addr_i = 24'h00ABCD; len_i = len[15:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mode > 5) chk(err_o == 1'b1, "R10", "err pulse", err_o, 1);
    else          chk(err_o == 1'b0 && !busy_o, "R11", "zero count busy/err", busy_o, 0);
    @(negedge clk);
    chk(err_o == 1'b0, req, "err cleared", err_o, 0);
    repeat (20) @(negedge clk);
    chk(cs_low_cnt == cs0 && !busy_o, req, "cs stayed high", cs_low_cnt - cs0, 0);
  endtask

  task automatic run_all();
    logic [23:0] addrs [3];
    addrs[0] = 24'h000000; addrs[1] = 24'h1234FE; addrs[2] = 24'hFFFFFE;
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sck_o && io_oe_o == 4'b0000 && !valid_o && !busy_o && !err_o,
        "R12", "reset state", {cs_n_o, sck_o, io_oe_o}, 6'b100000);
    rst_ni = 1'b1;
    for (int m = 0; m < 6; m++)
      for (int ai = 0; ai < 3; ai++)
        for (int li = 0; li < 2; li++)
          run_xfer(m, addrs[ai], (li == 0) ? 1 : 3, (m + ai + li) % 3);
    run_xfer(5, 24'h00F0F0, 40, 2);
    run_xfer(0, 24'h7FFFF0, 20, 1);
    run_xfer(4, 24'hABCDEF, 17, 2);
    run_reject(6, 4, "R10");
    run_reject(7, 1, "R10");
    run_reject(2, 0, "R11");
    run_xfer(3, 24'h55AA55, 6, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", cyc, 190000);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule